// File: doc/BRIEF.md
# Firmware-Hub Target Cycle Decoder

This block sits on the target side of a nibble-serial firmware-hub bus. On each clock it samples an active-low frame strobe and a 4-bit data bus. It recognises the start of a read or write cycle and checks an ID-select nibble against a strap input. It then collects seven address nibbles, a size nibble and, for writes, two data nibbles. Once every field is in, it presents a single request to the memory side. The request carries a 20-bit device address, a flag that steers the access to the flash core or to the register space, the direction and the write byte.

Invalid fields are dropped without any response. If the ID does not match, or the size nibble is not zero, the decoder goes back to idle and no request is made. If the frame strobe is sampled low while a cycle is being collected, the cycle ends. The decoder then stays parked until the bus carries the all-ones nibble.

The memory side uses a valid/ready handshake. The payload is held stable while valid is high and ready is low. A transfer happens on a clock where both are high. While a request is waiting, the decoder does not sample the bus. The driving, turnaround and sync phases are not part of this block.

Top module: `fwh_cycle_decoder`

## Requirements
- R1: In idle, a sample with frame_n low and nibble 4'hD starts a read and 4'hE starts a write; any other start nibble, or those nibbles with frame_n high, start nothing.
- R2: The nibble after the start must equal id_strap; on a mismatch the cycle is dropped silently and no request is raised.
- R3: Seven address nibbles follow, most significant first (28 bits); req_addr carries the last five nibbles, i.e. bits 19:0 of the 28-bit address.
- R4: req_core equals bit 22 of the 28-bit address (bit 2 of the second address nibble): 1 selects the flash core, 0 the register space.
- R5: A size nibble other than 4'h0 returns the decoder to idle with no request; a following valid cycle is served normally.
- R6: For a write, the two nibbles after the size nibble form req_wdata, low nibble first; req_write is 1 for writes and 0 for reads.
- R7: req_valid rises on the clock that captures the last field. It stays high, with every payload output stable, until a clock with req_ready high, and it is low on the next clock. While it is high, the bus is not sampled.
- R8: frame_n sampled low during the ID, address, size or data phase ends the cycle, and no request follows.
- R9: After an abort, the decoder ignores all bus activity, including start nibbles, until it samples 4'hF; from the next clock a new cycle can start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame strobe |
| nib_i | input | 4 | Nibble-serial data bus |
| id_strap | input | 4 | ID value this target answers to |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Memory side accepts the request |
| req_write | output | 1 | 1 = write, 0 = read |
| req_core | output | 1 | 1 = flash core, 0 = register space |
| req_addr | output | 20 | Device address |
| req_wdata | output | 8 | Write byte (meaningful when req_write is 1) |

## Verification
The assertions assume that frame_n, nib_i and req_ready change only away from the rising edge. They also assume that id_strap is a static strap that never moves during a run. req_ready is taken to carry meaning only while req_valid is high. The bench drives every input on the falling edge, sets id_strap once before reset is released, and raises req_ready only after it has seen a request. The abort tests keep 4'hF out of the cycles they drive during abort-wait, so the only exit from that state is the deliberate abort nibble.

// File: rtl/fwh_pkg.sv
package fwh_pkg;
  localparam int unsigned NIB_W = 4;

  localparam logic [NIB_W-1:0] NIB_START_RD = 4'hD;
  localparam logic [NIB_W-1:0] NIB_START_WR = 4'hE;
  localparam logic [NIB_W-1:0] NIB_ABORT    = 4'hF;
  localparam logic [NIB_W-1:0] NIB_SIZE_OK  = 4'h0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ID,
    ST_ADDR,
    ST_SIZE,
    ST_DATA,
    ST_REQ,
    ST_ABORT
  } fwh_state_e;
endpackage

// File: rtl/fwh_seq_fsm.sv
module fwh_seq_fsm
  import fwh_pkg::*;
#(
  parameter int unsigned ADDR_NIBS = 7,
  parameter int unsigned DATA_NIBS = 2,
  localparam int unsigned MAX_NIBS = (ADDR_NIBS > DATA_NIBS) ? ADDR_NIBS : DATA_NIBS,
  localparam int unsigned CNT_W    = (MAX_NIBS > 1) ? $clog2(MAX_NIBS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic [NIB_W-1:0] nib_i,
  input  logic [NIB_W-1:0] id_strap,
  input  logic             req_ready,
  output fwh_state_e       state_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             addr_en,
  output logic             data_en,
  output logic             is_write,
  output logic             req_valid
);
  fwh_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wr_q, wr_d;
  logic             in_cycle;
  logic             cut;

  assign in_cycle = (state_q == ST_ID) || (state_q == ST_ADDR) ||
                    (state_q == ST_SIZE) || (state_q == ST_DATA);
  assign cut      = in_cycle && !frame_n;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    wr_d    = wr_q;
    if (cut) begin
      state_d = ST_ABORT;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (!frame_n && nib_i == NIB_START_RD) begin
            state_d = ST_ID;
            wr_d    = 1'b0;
          end else if (!frame_n && nib_i == NIB_START_WR) begin
            state_d = ST_ID;
            wr_d    = 1'b1;
          end
        end
        ST_ID: begin
          cnt_d   = '0;
          state_d = (nib_i == id_strap) ? ST_ADDR : ST_IDLE;
        end
        ST_ADDR: begin
          if (cnt_q == CNT_W'(ADDR_NIBS - 1)) begin
            state_d = ST_SIZE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_SIZE: begin
          if (nib_i != NIB_SIZE_OK) state_d = ST_IDLE;
          else if (wr_q)            state_d = ST_DATA;
          else                      state_d = ST_REQ;
        end
        ST_DATA: begin
          if (cnt_q == CNT_W'(DATA_NIBS - 1)) begin
            state_d = ST_REQ;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_REQ: begin
          if (req_ready) state_d = ST_IDLE;
        end
        ST_ABORT: begin
          if (nib_i == NIB_ABORT) state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      wr_q    <= wr_d;
    end
  end

  assign state_o   = state_q;
  assign cnt_o     = cnt_q;
  assign addr_en   = (state_q == ST_ADDR) && frame_n;
  assign data_en   = (state_q == ST_DATA) && frame_n;
  assign is_write  = wr_q;
  assign req_valid = (state_q == ST_REQ);

  // R8: a low frame strobe during collection parks the sequencer
  p_abort_enter_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cycle && !frame_n) |=> (state_q == ST_ABORT));

  // R9: only the all-ones nibble leaves abort-wait
  p_abort_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ABORT && nib_i != NIB_ABORT) |=> (state_q == ST_ABORT));

  // R2: ID mismatch drops the cycle
  p_id_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ID && frame_n && nib_i != id_strap) |=> (state_q == ST_IDLE));

  // R5: non-zero size drops the cycle
  p_size_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SIZE && frame_n && nib_i != NIB_SIZE_OK) |=> (state_q == ST_IDLE));

  // R1: idle leaves only on a start nibble with frame low
  p_start_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && (frame_n || (nib_i != NIB_START_RD && nib_i != NIB_START_WR)))
      |=> (state_q == ST_IDLE));

  // R3: field counter stays in range
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q < CNT_W'(MAX_NIBS)));
endmodule

// File: rtl/fwh_field_capture.sv
module fwh_field_capture
  import fwh_pkg::*;
#(
  parameter int unsigned ADDR_NIBS = 7,
  parameter int unsigned KEEP_NIBS = 5,
  parameter int unsigned DATA_NIBS = 2,
  parameter int unsigned STEER_BIT = 22,
  parameter int unsigned CNT_W     = 3,
  localparam int unsigned KEEP_W    = KEEP_NIBS * NIB_W,
  localparam int unsigned DATA_W    = DATA_NIBS * NIB_W,
  localparam int unsigned STEER_IDX = ADDR_NIBS - 1 - STEER_BIT / NIB_W,
  localparam int unsigned STEER_POS = STEER_BIT % NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIB_W-1:0]  nib_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              addr_en,
  input  logic              data_en,
  output logic [KEEP_W-1:0] addr_o,
  output logic              steer_o,
  output logic [DATA_W-1:0] data_o
);
  logic [KEEP_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              steer_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      steer_q <= 1'b0;
    end else if (addr_en) begin
      addr_q <= {addr_q[KEEP_W-NIB_W-1:0], nib_i};
      if (cnt_i == CNT_W'(STEER_IDX)) steer_q <= nib_i[STEER_POS];
    end
  end

  generate
    if (DATA_NIBS > 1) begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       data_q <= '0;
        else if (data_en) data_q <= {nib_i, data_q[DATA_W-1:NIB_W]};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       data_q <= '0;
        else if (data_en) data_q <= nib_i;
      end
    end
  endgenerate

  assign addr_o  = addr_q;
  assign steer_o = steer_q;
  assign data_o  = data_q;

  // R3: address holds whenever no address nibble is taken
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_en) |=> $stable(addr_q));
endmodule

// File: rtl/fwh_cycle_decoder.sv
module fwh_cycle_decoder
  import fwh_pkg::*;
#(
  parameter int unsigned ADDR_NIBS = 7,
  parameter int unsigned KEEP_NIBS = 5,
  parameter int unsigned DATA_NIBS = 2,
  parameter int unsigned STEER_BIT = 22,
  localparam int unsigned KEEP_W   = KEEP_NIBS * NIB_W,
  localparam int unsigned DATA_W   = DATA_NIBS * NIB_W,
  localparam int unsigned MAX_NIBS = (ADDR_NIBS > DATA_NIBS) ? ADDR_NIBS : DATA_NIBS,
  localparam int unsigned CNT_W    = (MAX_NIBS > 1) ? $clog2(MAX_NIBS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic [3:0]        nib_i,
  input  logic [3:0]        id_strap,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic              req_core,
  output logic [KEEP_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata
);
  fwh_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             addr_en, data_en, is_write;

  fwh_seq_fsm #(
    .ADDR_NIBS(ADDR_NIBS),
    .DATA_NIBS(DATA_NIBS)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_n  (frame_n),
    .nib_i    (nib_i),
    .id_strap (id_strap),
    .req_ready(req_ready),
    .state_o  (state),
    .cnt_o    (cnt),
    .addr_en  (addr_en),
    .data_en  (data_en),
    .is_write (is_write),
    .req_valid(req_valid)
  );

  fwh_field_capture #(
    .ADDR_NIBS(ADDR_NIBS),
    .KEEP_NIBS(KEEP_NIBS),
    .DATA_NIBS(DATA_NIBS),
    .STEER_BIT(STEER_BIT),
    .CNT_W    (CNT_W)
  ) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .nib_i  (nib_i),
    .cnt_i  (cnt),
    .addr_en(addr_en),
    .data_en(data_en),
    .addr_o (req_addr),
    .steer_o(req_core),
    .data_o (req_wdata)
  );

  assign req_write = is_write;

  // R7: a stalled request keeps its payload
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
      $stable(req_core) && $stable(req_write) && $stable(req_wdata)));

  // R7: a request drops right after the handshake
  p_req_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_valid);

  // R8: no request can follow an abort directly
  p_no_req_after_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ABORT) |=> !req_valid);
endmodule

// File: tb/test_fwh_cycle_decoder.sv
`timescale 1ns/1ps
module test_fwh_cycle_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic [3:0]  nib_i = 4'h0;
  logic [3:0]  id_strap = 4'h6;
  logic        req_valid, req_ready = 1'b0;
  logic        req_write, req_core;
  logic [19:0] req_addr;
  logic [7:0]  req_wdata;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  fwh_cycle_decoder i_fwh_cycle_decoder (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .nib_i(nib_i),
    .id_strap(id_strap), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_core(req_core), .req_addr(req_addr),
    .req_wdata(req_wdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic f, input logic [3:0] n);
    @(negedge clk);
    frame_n = f;
    nib_i   = n;
  endtask

  task automatic settle();
    @(negedge clk);
    frame_n = 1'b1;
    nib_i   = 4'h0;
  endtask

  task automatic send_cycle(input logic wr, input logic [3:0] id, input logic [27:0] a,
                            input logic [3:0] sz, input logic [7:0] d);
    send(1'b0, wr ? 4'hE : 4'hD);
    send(1'b1, id);
    for (int i = 6; i >= 0; i--) send(1'b1, a[i*4 +: 4]);
    send(1'b1, sz);
    if (wr && sz == 4'h0) begin
      send(1'b1, d[3:0]);
      send(1'b1, d[7:4]);
    end
    settle();
  endtask

  task automatic accept(input string tag);
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    check(tag, {31'd0, req_valid}, 32'd0);
  endtask

  task automatic t_read(input logic [27:0] a, input logic core);
    send_cycle(1'b0, id_strap, a, 4'h0, 8'h00);
    check("R7 read valid", {31'd0, req_valid}, 32'd1);
    check("R6 read dir", {31'd0, req_write}, 32'd0);
    check("R3 read addr", {12'd0, req_addr}, {12'd0, a[19:0]});
    check("R4 read core", {31'd0, req_core}, {31'd0, core});
    accept("R7 read release");
  endtask

  task automatic t_write(input logic [27:0] a, input logic core, input logic [7:0] d);
    send_cycle(1'b1, id_strap, a, 4'h0, d);
    check("R7 write valid", {31'd0, req_valid}, 32'd1);
    check("R6 write dir", {31'd0, req_write}, 32'd1);
    check("R6 write data", {24'd0, req_wdata}, {24'd0, d});
    check("R3 write addr", {12'd0, req_addr}, {12'd0, a[19:0]});
    check("R4 write core", {31'd0, req_core}, {31'd0, core});
    accept("R7 write release");
  endtask

  task automatic t_backpressure();
    send_cycle(1'b0, id_strap, 28'h1412345, 4'h0, 8'h00);
    for (int i = 0; i < 4; i++) begin
      send(1'b0, 4'hE);
      check("R7 stall valid", {31'd0, req_valid}, 32'd1);
      check("R7 stall addr", {12'd0, req_addr}, 32'h12345);
    end
    settle();
    accept("R7 stall release");
    settle();
    check("R7 bus ignored while pending", {31'd0, req_valid}, 32'd0);
  endtask

  task automatic t_bad_start();
    send(1'b0, 4'hC);
    send(1'b1, id_strap);
    for (int i = 0; i < 8; i++) send(1'b1, 4'h0);
    settle();
    check("R1 bad start nibble", {31'd0, req_valid}, 32'd0);
    send(1'b1, 4'hD);
    send(1'b1, id_strap);
    for (int i = 0; i < 8; i++) send(1'b1, 4'h0);
    settle();
    check("R1 start with frame high", {31'd0, req_valid}, 32'd0);
  endtask

  task automatic t_bad_id();
    send_cycle(1'b0, id_strap ^ 4'h1, 28'h1412345, 4'h0, 8'h00);
    check("R2 id mismatch", {31'd0, req_valid}, 32'd0);
    settle();
    check("R2 id mismatch later", {31'd0, req_valid}, 32'd0);
  endtask

  task automatic t_bad_size(input logic [3:0] sz);
    send_cycle(1'b1, id_strap, 28'h2C01234, sz, 8'h5A);
    check("R5 bad size", {31'd0, req_valid}, 32'd0);
    settle();
    check("R5 bad size later", {31'd0, req_valid}, 32'd0);
    t_read(28'h0B3A5C7, 1'b0);
  endtask

  task automatic t_abort(input int ph);
    send(1'b0, 4'hE);
    if (ph >= 1) send(1'b1, id_strap);
    if (ph >= 2) for (int i = 0; i < ((ph == 2) ? 3 : 7); i++) send(1'b1, 4'h2);
    if (ph >= 3) send(1'b1, 4'h0);
    if (ph >= 4) send(1'b1, 4'h5);
    send(1'b0, 4'h3);
    settle();
    check($sformatf("R8 abort phase %0d", ph), {31'd0, req_valid}, 32'd0);
    send_cycle(1'b0, id_strap, 28'h1412345, 4'h0, 8'h00);
    check($sformatf("R9 start ignored phase %0d", ph), {31'd0, req_valid}, 32'd0);
    send(1'b1, 4'hF);
    settle();
    t_read(28'h1412345, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R7 reset valid", {31'd0, req_valid}, 32'd0);
    check("R3 reset addr", {12'd0, req_addr}, 32'd0);
    rst_n = 1'b1;
    settle();
    t_read(28'h1412345, 1'b1);
    t_read(28'h0B3A5C7, 1'b0);
    t_write(28'h2C01234, 1'b1, 8'hA5);
    t_write(28'h0800001, 1'b0, 8'h3C);
    t_backpressure();
    t_bad_start();
    t_bad_id();
    t_bad_size(4'h1);
    t_bad_size(4'h8);
    for (int ph = 1; ph <= 4; ph++) t_abort(ph);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule